// File: doc/BRIEF.md
# Time Base Prescaler with Compare Timer

This block combines a free-running time base prescaler with an 8-bit up-counting compare timer. Both are configured by one 8-bit mode register. The prescaler counts pulses from one of two clock-enable inputs. It raises a periodic one-cycle interrupt at one of eight power-of-two intervals.

The timer counts pulses from one of five sources: the fast, system or slow clock enable, or one of two prescaler taps. When its count reaches a writable compare value, it wraps to zero and raises a one-cycle interrupt. Bit 7 of the mode register has two jobs. It decides whether a compare write restarts the count, and it picks which of two interrupt outputs carries the match.

Every input clock is modelled as a clock enable sampled on the single system clock `clk`.

Top module: `tbase_timer`

## Requirements
- R1: The mode register resets to 0x00, and a write through `mode_we` is read back unchanged on `mode_rdata`.
- R2: Mode bit 0 selects what advances the prescaler: 0 means `fast_en`, 1 means `slow_en`. The unselected enable has no effect.
- R3: Mode bits 6:4 (code c) set the time base interrupt period in prescaler counts. The period is 2^(7+c) for c = 0 to 3 and 2^(8+c) for c = 4 to 7, so 2^11 is never produced.
- R4: `tb_irq` is a one-cycle pulse. After reset the first pulse comes one cycle after the edge that takes the prescaler through its full selected period.
- R5: Mode bits 3:1 select the timer source: 000 means `fast_en`, 001 means `sys_en` and 010 means `slow_en`. Pulses on the other enables do not change the count.
- R6: The source codes 011, 101 and 111 stop the timer, and the count holds.
- R7: Source code 110 advances the timer once every 2^7 prescaler counts. Source code 100 advances it once every 2^13 prescaler counts.
- R8: The timer counts up by one on each selected pulse. A pulse that arrives while the count equals the compare value returns the count to zero and gives a one-cycle match interrupt. The match period is therefore compare + 1 pulses.
- R9: While mode bit 7 is 0, a compare write sets the count to zero.
- R10: While mode bit 7 is 1, a compare write leaves the count unchanged.
- R11: While mode bit 7 is 0, the match interrupt appears on `tmr_irq` and `aux_irq` stays low. While bit 7 is 1, it appears on `aux_irq` and `tmr_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_en | input | 1 | High-speed clock enable pulse |
| sys_en | input | 1 | System clock enable pulse |
| slow_en | input | 1 | Slow clock enable pulse |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register contents |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare register write data |
| tmr_count | output | 8 | Current timer count |
| tb_irq | output | 1 | Time base periodic interrupt pulse |
| tmr_irq | output | 1 | Match interrupt when mode bit 7 is 0 |
| aux_irq | output | 1 | Match interrupt when mode bit 7 is 1 |

## Verification
The bench measures the interval between successive time base pulses for all eight tap codes. A tap table that included divide-by-2^11, or that was shifted by one, would show up as a doubled or halved interval. It switches the timer from the 2^7 tap to the 2^13 tap and samples one cycle before and one cycle after the expected increment. A design that wired the wrong prescaler bit would be off by whole periods.

It drives every enable, including the unselected ones and the prohibited source codes, and confirms that the count moves only where it should. It issues compare writes with bit 7 in both states. A design that inverted the bit would clear the count when it should keep it, and would route the match to the wrong interrupt line.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  typedef struct packed {
    logic       keep_on_cmp;
    logic [2:0] tb_period;
    logic [2:0] tmr_src;
    logic       tb_slow;
  } mode_t;

  localparam logic [2:0] SRC_FAST  = 3'b000;
  localparam logic [2:0] SRC_SYS   = 3'b001;
  localparam logic [2:0] SRC_SLOW  = 3'b010;
  localparam logic [2:0] SRC_TAP13 = 3'b100;
  localparam logic [2:0] SRC_TAP7  = 3'b110;

  // Prescaler bit whose falling edge marks the period chosen by code c.
  function automatic int unsigned tap_bit(input logic [2:0] c);
    if (c < 3'd4) return 32'd6 + 32'(c);
    return 32'd7 + 32'(c);
  endfunction

endpackage

// File: rtl/tbt_mode_reg.sv
module tbt_mode_reg
  import tbt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output mode_t        mode
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (we) q <= wdata;
  end

  assign rdata = q;
  assign mode  = mode_t'(q[7:0]);

endmodule

// File: rtl/tbt_prescaler.sv
module tbt_prescaler
  import tbt_pkg::*;
#(
  parameter int TB_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic [2:0] period_code,
  output logic       tb_irq,
  output logic       tap7_tick,
  output logic       tap13_tick
);

  localparam int IDX_W = $clog2(TB_W);

  logic [TB_W-1:0]  cnt;
  logic [TB_W-1:0]  fall;
  logic [IDX_W-1:0] sel_idx;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  // Bit i falls on this advance when bits i..0 are all ones.
  for (genvar i = 0; i < TB_W; i++) begin : g_fall
    assign fall[i] = adv & (&cnt[i:0]);
  end

  assign sel_idx = IDX_W'(tap_bit(period_code));

  always_ff @(posedge clk) begin
    if (rst) tb_irq <= 1'b0;
    else     tb_irq <= fall[sel_idx];
  end

  assign tap7_tick  = fall[6];
  assign tap13_tick = fall[12];

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter
  import tbt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       src,
  input  logic             keep_on_cmp,
  input  logic             fast_en,
  input  logic             sys_en,
  input  logic             slow_en,
  input  logic             tap7_tick,
  input  logic             tap13_tick,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic             match
);

  logic [CNT_W-1:0] cmp_q;
  logic             tick;

  always_comb begin
    case (src)
      SRC_FAST:  tick = fast_en;
      SRC_SYS:   tick = sys_en;
      SRC_SLOW:  tick = slow_en;
      SRC_TAP13: tick = tap13_tick;
      SRC_TAP7:  tick = tap7_tick;
      default:   tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      cmp_q <= '0;
      match <= 1'b0;
    end else begin
      match <= 1'b0;
      if (cmp_we) cmp_q <= cmp_wdata;
      if (cmp_we && !keep_on_cmp) begin
        count <= '0;
      end else if (tick) begin
        if (count == cmp_q) begin
          count <= '0;
          match <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbt_pkg::*;
#(
  parameter int TB_W  = 15,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_en,
  input  logic             sys_en,
  input  logic             slow_en,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  output logic [7:0]       mode_rdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] tmr_count,
  output logic             tb_irq,
  output logic             tmr_irq,
  output logic             aux_irq
);

  mode_t mode;
  logic  tb_adv;
  logic  tap7_tick;
  logic  tap13_tick;
  logic  match;

  tbt_mode_reg #(.W(8)) u_mode (
    .clk   (clk),
    .rst   (rst),
    .we    (mode_we),
    .wdata (mode_wdata),
    .rdata (mode_rdata),
    .mode  (mode)
  );

  assign tb_adv = mode.tb_slow ? slow_en : fast_en;

  tbt_prescaler #(.TB_W(TB_W)) u_pre (
    .clk         (clk),
    .rst         (rst),
    .adv         (tb_adv),
    .period_code (mode.tb_period),
    .tb_irq      (tb_irq),
    .tap7_tick   (tap7_tick),
    .tap13_tick  (tap13_tick)
  );

  tbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .src         (mode.tmr_src),
    .keep_on_cmp (mode.keep_on_cmp),
    .fast_en     (fast_en),
    .sys_en      (sys_en),
    .slow_en     (slow_en),
    .tap7_tick   (tap7_tick),
    .tap13_tick  (tap13_tick),
    .cmp_we      (cmp_we),
    .cmp_wdata   (cmp_wdata),
    .count       (tmr_count),
    .match       (match)
  );

  assign tmr_irq = match & ~mode.keep_on_cmp;
  assign aux_irq = match &  mode.keep_on_cmp;

endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       mode_rdata,
  input logic             mode_we,
  input logic             cmp_we,
  input logic [CNT_W-1:0] tmr_count,
  input logic             tmr_irq,
  input logic             aux_irq
);

  // R11: the secondary interrupt line stays quiet while bit 7 is clear
  p_aux_gated_r11: assert property (@(posedge clk) disable iff (rst)
    aux_irq |-> mode_rdata[7]);

  // R11: the two interrupt lines are never active together
  p_irq_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tmr_irq, aux_irq}));

  // R9: a compare write with bit 7 clear restarts the count
  p_cmp_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && !mode_rdata[7]) |=> (tmr_count == '0));

  // R10: a compare write with bit 7 set and the timer stopped keeps the count
  p_cmp_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_we && mode_rdata[7] && mode_rdata[3:1] == 3'b011 && !mode_we)
      |=> $stable(tmr_count));

  // R6: a prohibited source code holds the count
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_rdata[3:1] inside {3'b011, 3'b101, 3'b111} && !cmp_we && !mode_we)
      |=> $stable(tmr_count));

  // R8: every match interrupt coincides with a count of zero
  p_match_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (tmr_irq || aux_irq) |-> (tmr_count == '0));

endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mode_rdata (mode_rdata),
  .mode_we    (mode_we),
  .cmp_we     (cmp_we),
  .tmr_count  (tmr_count),
  .tmr_irq    (tmr_irq),
  .aux_irq    (aux_irq)
);

// File: tb/tbase_timer_tb_top.sv
module tbase_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fast_en = 1'b0, sys_en = 1'b0, slow_en = 1'b0;
  logic       mode_we = 1'b0, cmp_we = 1'b0;
  logic [7:0] mode_wdata = '0, cmp_wdata = '0;
  logic [7:0] mode_rdata, tmr_count;
  logic       tb_irq, tmr_irq, aux_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tbase_timer dut_i (
    .clk        (clk),
    .rst        (rst),
    .fast_en    (fast_en),
    .sys_en     (sys_en),
    .slow_en    (slow_en),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .mode_rdata (mode_rdata),
    .cmp_we     (cmp_we),
    .cmp_wdata  (cmp_wdata),
    .tmr_count  (tmr_count),
    .tb_irq     (tb_irq),
    .tmr_irq    (tmr_irq),
    .aux_irq    (aux_irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fast_en = 0; sys_en = 0; slow_en = 0; mode_we = 0; cmp_we = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = v;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  // sel: 0 fast, 1 sys, 2 slow, 3 all
  task automatic pulse(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fast_en = (sel == 0 || sel == 3);
      sys_en  = (sel == 1 || sel == 3);
      slow_en = (sel == 2 || sel == 3);
      @(negedge clk);
      fast_en = 0; sys_en = 0; slow_en = 0;
    end
  endtask

  task automatic t_mode_reg();
    do_reset();
    check("R1", "mode after reset", mode_rdata, 0);
    check("R1", "count after reset", tmr_count, 0);
    check("R1", "irqs after reset", {tb_irq, tmr_irq, aux_irq}, 0);
    wr_mode(8'hA5);
    check("R1", "mode readback", mode_rdata, 8'hA5);
    do_reset();
    check("R1", "mode after second reset", mode_rdata, 0);
  endtask

  task automatic t_first_pulse();
    int n;
    do_reset();
    n = 0;
    fast_en = 1'b1;
    while (!tb_irq && n < 1000) begin @(negedge clk); n++; end
    check("R4", "cycles to first tb pulse", n, 128);
    @(negedge clk);
    check("R4", "tb pulse width", tb_irq, 0);
    fast_en = 1'b0;
  endtask

  task automatic t_periods();
    int n;
    do_reset();
    for (int c = 0; c < 8; c++) begin
      int exp_p;
      exp_p = (c < 4) ? (1 << (7 + c)) : (1 << (8 + c));
      fast_en = 1'b0;
      wr_mode(8'(c << 4));
      fast_en = 1'b1;
      n = 0;
      while (!tb_irq && n < 40000) begin @(negedge clk); n++; end
      @(negedge clk);
      n = 1;
      while (!tb_irq && n < 40000) begin @(negedge clk); n++; end
      check("R3", $sformatf("tb period code %0d", c), n, exp_p);
    end
    fast_en = 1'b0;
  endtask

  task automatic t_slow_tb();
    int pulses;
    int guard;
    do_reset();
    wr_mode(8'h01);
    pulses = 0;
    guard = 0;
    fast_en = 1'b1;
    while (!tb_irq && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (!tb_irq) begin
        slow_en = ~slow_en;
        if (slow_en) pulses++;
      end
    end
    check("R2", "slow pulses to tb pulse (fast ignored)", pulses, 128);
    fast_en = 1'b0; slow_en = 1'b0;
  endtask

  task automatic t_sources();
    do_reset();
    wr_cmp(8'hFF);
    wr_mode(8'h02);
    pulse(1, 5);
    check("R5", "sys source count", tmr_count, 5);
    pulse(0, 3); pulse(2, 3);
    check("R5", "sys source ignores others", tmr_count, 5);
    wr_mode(8'h04);
    pulse(2, 2); pulse(1, 2);
    check("R5", "slow source count", tmr_count, 7);
    wr_mode(8'h00);
    pulse(0, 1); pulse(1, 2);
    check("R5", "fast source count", tmr_count, 8);
    wr_mode(8'h06); pulse(3, 4);
    check("R6", "code 011 holds", tmr_count, 8);
    wr_mode(8'h0A); pulse(3, 4);
    check("R6", "code 101 holds", tmr_count, 8);
    wr_mode(8'h0E); pulse(3, 4);
    check("R6", "code 111 holds", tmr_count, 8);
  endtask

  task automatic t_taps();
    do_reset();
    wr_cmp(8'hFF);
    wr_mode(8'h0C);
    @(negedge clk); fast_en = 1'b1;
    repeat (384) @(negedge clk);
    fast_en = 1'b0;
    check("R7", "tap 2^7 count after 384", tmr_count, 3);
    wr_mode(8'h08);
    @(negedge clk); fast_en = 1'b1;
    repeat (8192 - 384 - 1) @(negedge clk);
    fast_en = 1'b0;
    check("R7", "tap 2^13 one before", tmr_count, 3);
    @(negedge clk); fast_en = 1'b1;
    @(negedge clk); fast_en = 1'b0;
    check("R7", "tap 2^13 at boundary", tmr_count, 4);
  endtask

  task automatic match_run(input string req, input int exp_t, input int exp_a);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); fast_en = 1'b1;
      @(negedge clk); fast_en = 1'b0;
      check(req, $sformatf("tmr_irq on pulse %0d", i), tmr_irq, (i == 4) ? exp_t : 0);
      check(req, $sformatf("aux_irq on pulse %0d", i), aux_irq, (i == 4) ? exp_a : 0);
      check("R8", $sformatf("count after pulse %0d", i), tmr_count, i % 4);
    end
    @(negedge clk);
    check("R8", "irq is one cycle", {tmr_irq, aux_irq}, 0);
  endtask

  task automatic t_match();
    do_reset();
    wr_cmp(8'd3);
    match_run("R11", 1, 0);
    match_run("R8", 1, 0);
    wr_mode(8'h80);
    match_run("R11", 0, 1);
  endtask

  task automatic t_cmp_write();
    do_reset();
    wr_cmp(8'd200);
    pulse(0, 5);
    check("R9", "count before cmp write", tmr_count, 5);
    wr_cmp(8'd200);
    check("R9", "cmp write clears", tmr_count, 0);
    wr_mode(8'h80);
    pulse(0, 5);
    wr_cmp(8'd7);
    check("R10", "cmp write keeps", tmr_count, 5);
    pulse(0, 2);
    check("R10", "count reaches new cmp", tmr_count, 7);
    @(negedge clk); fast_en = 1'b1;
    @(negedge clk); fast_en = 1'b0;
    check("R10", "wrap at new cmp", tmr_count, 0);
    check("R11", "aux at new cmp", aux_irq, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_mode_reg();
    t_first_pulse();
    t_slow_tb();
    t_sources();
    t_match();
    t_cmp_write();
    t_taps();
    t_periods();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule